// File: doc/BRIEF.md
# Transmit Queue Start Gate

This block sits beside a bank of transmit queues and decides, for each queue independently, when the packet at the head of that queue may begin moving toward the MAC. It watches the write side of every queue, adding up the bytes that arrive for the head packet and noting when the beat that closes the packet has been written. From that tally and the queue's configuration it raises a per-queue start grant.

Each queue runs in one of two modes, chosen by its own bit of a mode vector. In cut-through mode, a 3-bit code picks a byte threshold. The grant rises once the bytes held for the head packet are strictly above that threshold, or as soon as the packet is complete, whichever comes first. In whole-packet mode, the threshold code is not used. The grant rises only when the packet is complete. There is one exception. If the packet fills the queue's capacity, which is (size code + 1) × 256 bytes, before its last beat arrives, the queue is released anyway and an oversize flag is raised.

A grant stays high until the read side pulls out the final beat of the packet. That beat clears the tally for the next packet. The writer is expected to begin a new packet in a queue only after that queue's grant for the previous one has dropped.

Top module: `txq_release`

## Requirements
- R1: In cut-through mode the threshold code selects a limit of 64, 64, 96, 128, 192, 256, 384 or 512 bytes for codes 0 to 7 respectively (code 1, otherwise unused, behaves as 64), and the grant rises once the head packet's written byte total is greater than that limit.
- R2: In cut-through mode, a head packet whose byte total equals the limit exactly, and is not complete, gets no grant.
- R3: In cut-through mode, a complete packet shorter than the limit is granted.
- R4: In whole-packet mode (mode bit 1), the grant rises only after the end-of-packet beat has been written, whatever the threshold code and the byte total below capacity.
- R5: Bit q of the mode vector governs queue q alone; other queues keep their own mode.
- R6: In whole-packet mode, an incomplete packet whose total reaches (size code + 1) × 256 bytes is granted, and the oversize flag of that queue rises together with its grant; the flag stays low in cut-through mode.
- R7: Once raised, a grant stays high through read beats that do not carry end-of-packet.
- R8: A read beat with end-of-packet on a granted queue drops its grant and oversize flag at that clock edge, and the following packet's tally starts from zero.
- R9: The grant rises at the first clock edge after the edge that registered the write beat meeting the release condition.
- R10: Read beats on a queue without a grant have no effect on its tally or grant.
- R11: Reset clears every grant and oversize flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfEn | input | NUM_Q | Per-queue whole-packet mode select |
| thrCode | input | NUM_Q*3 | Per-queue threshold code |
| sizeCode | input | NUM_Q*SIZE_W | Per-queue capacity code, 256-byte units minus one |
| wrValid | input | NUM_Q | Write beat present for queue |
| wrBytes | input | NUM_Q*BYTE_W | Bytes carried by the write beat |
| wrEop | input | NUM_Q | Write beat closes the packet |
| rdValid | input | NUM_Q | Beat read out toward the MAC |
| rdEop | input | NUM_Q | Read beat is the packet's last |
| grant | output | NUM_Q | Start-transmit grant |
| oversize | output | NUM_Q | Whole-packet release forced by full queue |

## Verification
Each threshold code is driven with a byte total sitting exactly on its limit and with one byte more. This separates "greater than" from "greater or equal" and catches a wrong entry in the code table, including the unused code. Short complete packets, whole-packet mode with and without the closing beat, and totals one byte under and exactly at capacity separate the completion path from the capacity escape. Reads with and without end-of-packet, stray reads on an idle queue, and mixed mode bits across queues show whether the grant holds, clears and stays per queue as required.

// File: rtl/txrel_pkg.sv
package txrel_pkg;

  // Strobes from the control to the byte-tally datapath of one queue.
  typedef struct packed {
    logic accept;  // add the current write beat to the tally
    logic clear;   // packet has left: restart the tally
  } dpStrobe_t;

  localparam int THR_W = 10;

  // Byte limit chosen by a threshold code; the unused code acts as the smallest.
  function automatic logic [THR_W-1:0] thresholdBytes(input logic [2:0] code);
    logic [THR_W-1:0] lim;
    case (code)
      3'd0, 3'd1: lim = 10'd64;
      3'd2:       lim = 10'd96;
      3'd3:       lim = 10'd128;
      3'd4:       lim = 10'd192;
      3'd5:       lim = 10'd256;
      3'd6:       lim = 10'd384;
      default:    lim = 10'd512;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/txrel_datapath.sv
module txrel_datapath
  import txrel_pkg::*;
#(
  parameter int BYTE_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] wrBytes,
  input  logic              wrEop,
  output logic [CNT_W-1:0]  headBytes,
  output logic              headDone
);

  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] sumSat;

  always_comb begin
    sumWide = {1'b0, headBytes} + (CNT_W+1)'(wrBytes);
    sumSat  = sumWide[CNT_W] ? {CNT_W{1'b1}} : sumWide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      headBytes <= '0;
      headDone  <= 1'b0;
    end else if (strobe.accept) begin
      headBytes <= sumSat;
      if (wrEop) headDone <= 1'b1;
    end
  end

endmodule

// File: rtl/txrel_ctrl.sv
module txrel_ctrl
  import txrel_pkg::*;
#(
  parameter int SIZE_W = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfMode,
  input  logic [2:0]        thrCode,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic              wrValid,
  input  logic              rdValid,
  input  logic              rdEop,
  input  logic [CNT_W-1:0]  headBytes,
  input  logic              headDone,
  output dpStrobe_t         strobe,
  output logic              grant,
  output logic              oversize
);

  logic [CNT_W-1:0] capBytes;
  logic [CNT_W-1:0] limBytes;
  logic             atCapacity;
  logic             overLimit;
  logic             releaseNow;
  logic             packetOut;

  always_comb begin
    capBytes   = (CNT_W'(sizeCode) + CNT_W'(1)) << 8;
    limBytes   = CNT_W'(thresholdBytes(thrCode));
    atCapacity = headBytes >= capBytes;
    overLimit  = headBytes > limBytes;
    releaseNow = headDone || (sfMode ? atCapacity : overLimit);
    packetOut  = grant && rdValid && rdEop;
    strobe.clear  = packetOut;
    strobe.accept = wrValid && !headDone && !packetOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant    <= 1'b0;
      oversize <= 1'b0;
    end else if (packetOut) begin
      grant    <= 1'b0;
      oversize <= 1'b0;
    end else if (!grant && releaseNow) begin
      grant    <= 1'b1;
      oversize <= sfMode && !headDone;
    end
  end

endmodule

// File: rtl/txq_release.sv
module txq_release
  import txrel_pkg::*;
#(
  parameter int NUM_Q      = 8,
  parameter int BEAT_BYTES = 16,
  parameter int SIZE_W     = 7,
  localparam int BYTE_W    = $clog2(BEAT_BYTES + 1),
  localparam int CNT_W     = $clog2((2 ** SIZE_W) * 256 + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_Q-1:0]        sfEn,
  input  logic [NUM_Q*3-1:0]      thrCode,
  input  logic [NUM_Q*SIZE_W-1:0] sizeCode,
  input  logic [NUM_Q-1:0]        wrValid,
  input  logic [NUM_Q*BYTE_W-1:0] wrBytes,
  input  logic [NUM_Q-1:0]        wrEop,
  input  logic [NUM_Q-1:0]        rdValid,
  input  logic [NUM_Q-1:0]        rdEop,
  output logic [NUM_Q-1:0]        grant,
  output logic [NUM_Q-1:0]        oversize
);

  logic [NUM_Q-1:0] headDone;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    dpStrobe_t        strobe;
    logic [CNT_W-1:0] headBytes;

    txrel_datapath #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) dp_i (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .wrBytes  (wrBytes[q*BYTE_W +: BYTE_W]),
      .wrEop    (wrEop[q]),
      .headBytes(headBytes),
      .headDone (headDone[q])
    );

    txrel_ctrl #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) ctrl_i (
      .clk      (clk),
      .rstN     (rstN),
      .sfMode   (sfEn[q]),
      .thrCode  (thrCode[q*3 +: 3]),
      .sizeCode (sizeCode[q*SIZE_W +: SIZE_W]),
      .wrValid  (wrValid[q]),
      .rdValid  (rdValid[q]),
      .rdEop    (rdEop[q]),
      .headBytes(headBytes),
      .headDone (headDone[q]),
      .strobe   (strobe),
      .grant    (grant[q]),
      .oversize (oversize[q])
    );
  end

endmodule

// File: rtl/txrel_checker.sv
module txrel_checker #(
  parameter int NUM_Q = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [NUM_Q-1:0] sfEn,
  input logic [NUM_Q-1:0] rdValid,
  input logic [NUM_Q-1:0] rdEop,
  input logic [NUM_Q-1:0] grant,
  input logic [NUM_Q-1:0] oversize,
  input logic [NUM_Q-1:0] headDone
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
    // R7: grant holds until the closing beat is read
    p_hold_until_eop_r7: assert property (@(posedge clk) disable iff (!rstN)
      grant[q] && !(rdValid[q] && rdEop[q]) |=> grant[q]);

    // R8: closing read beat drops grant and flag
    p_drop_after_eop_r8: assert property (@(posedge clk) disable iff (!rstN)
      grant[q] && rdValid[q] && rdEop[q] |=> !grant[q] && !oversize[q]);

    // R6: flag only alongside a grant
    p_oversize_with_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
      oversize[q] |-> grant[q]);

    // R6: flag only raised from whole-packet mode
    p_oversize_only_sf_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(oversize[q]) |-> $past(sfEn[q]));

    // R4: a whole-packet grant without the flag needs a complete packet
    p_sf_needs_complete_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grant[q]) && $past(sfEn[q]) && !oversize[q] |-> headDone[q]);
  end

endmodule

bind txq_release txrel_checker #(.NUM_Q(NUM_Q)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .sfEn    (sfEn),
  .rdValid (rdValid),
  .rdEop   (rdEop),
  .grant   (grant),
  .oversize(oversize),
  .headDone(headDone)
);

// File: tb/txq_release_tb_top.sv
module txq_release_tb_top;

  localparam int NUM_Q  = 8;
  localparam int BEAT   = 16;
  localparam int SIZE_W = 7;
  localparam int BYTE_W = $clog2(BEAT + 1);

  typedef struct packed {
    logic [2:0] q;
    logic       sf;
    logic [2:0] thr;
    logic [6:0] size;
    logic [5:0] nFull;
    logic [4:0] last;
    logic       eop;
    logic       expG;
    logic       expO;
  } vec_t;

  localparam int NV = 22;
  // q, sf, thr, size, full beats, last-beat bytes, eop, grant, oversize
  localparam vec_t TABLE [NV] = '{
    '{3'd0, 1'b0, 3'd0, 7'd127, 6'd4,  5'd1,  1'b0, 1'b1, 1'b0},  // R1 65>64
    '{3'd1, 1'b0, 3'd0, 7'd127, 6'd3,  5'd16, 1'b0, 1'b0, 1'b0},  // R2 64
    '{3'd2, 1'b0, 3'd1, 7'd127, 6'd4,  5'd1,  1'b0, 1'b1, 1'b0},  // R1 code1
    '{3'd3, 1'b0, 3'd2, 7'd127, 6'd5,  5'd16, 1'b0, 1'b0, 1'b0},  // R2 96
    '{3'd3, 1'b0, 3'd2, 7'd127, 6'd6,  5'd1,  1'b0, 1'b1, 1'b0},  // R1 97
    '{3'd4, 1'b0, 3'd3, 7'd127, 6'd7,  5'd16, 1'b0, 1'b0, 1'b0},  // R2 128
    '{3'd4, 1'b0, 3'd3, 7'd127, 6'd8,  5'd1,  1'b0, 1'b1, 1'b0},  // R1 129
    '{3'd5, 1'b0, 3'd4, 7'd127, 6'd11, 5'd16, 1'b0, 1'b0, 1'b0},  // R2 192
    '{3'd5, 1'b0, 3'd4, 7'd127, 6'd12, 5'd1,  1'b0, 1'b1, 1'b0},  // R1 193
    '{3'd6, 1'b0, 3'd5, 7'd127, 6'd15, 5'd16, 1'b0, 1'b0, 1'b0},  // R2 256
    '{3'd6, 1'b0, 3'd5, 7'd127, 6'd16, 5'd1,  1'b0, 1'b1, 1'b0},  // R1 257
    '{3'd7, 1'b0, 3'd6, 7'd127, 6'd23, 5'd16, 1'b0, 1'b0, 1'b0},  // R2 384
    '{3'd7, 1'b0, 3'd6, 7'd127, 6'd24, 5'd1,  1'b0, 1'b1, 1'b0},  // R1 385
    '{3'd0, 1'b0, 3'd7, 7'd127, 6'd31, 5'd16, 1'b0, 1'b0, 1'b0},  // R2 512
    '{3'd0, 1'b0, 3'd7, 7'd127, 6'd32, 5'd1,  1'b0, 1'b1, 1'b0},  // R1 513
    '{3'd1, 1'b0, 3'd7, 7'd127, 6'd0,  5'd16, 1'b1, 1'b1, 1'b0},  // R3 short
    '{3'd2, 1'b1, 3'd0, 7'd127, 6'd9,  5'd16, 1'b0, 1'b0, 1'b0},  // R4 no eop
    '{3'd2, 1'b1, 3'd0, 7'd127, 6'd9,  5'd16, 1'b1, 1'b1, 1'b0},  // R4 eop
    '{3'd3, 1'b1, 3'd0, 7'd0,   6'd15, 5'd15, 1'b0, 1'b0, 1'b0},  // R6 255
    '{3'd3, 1'b1, 3'd0, 7'd0,   6'd15, 5'd16, 1'b0, 1'b1, 1'b1},  // R6 256
    '{3'd4, 1'b1, 3'd7, 7'd1,   6'd31, 5'd15, 1'b0, 1'b0, 1'b0},  // R6 511
    '{3'd4, 1'b1, 3'd7, 7'd1,   6'd31, 5'd16, 1'b0, 1'b1, 1'b1}   // R6 512
  };

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [NUM_Q-1:0]        sfEn = '0;
  logic [NUM_Q*3-1:0]      thrCode = '0;
  logic [NUM_Q*SIZE_W-1:0] sizeCode = '1;
  logic [NUM_Q-1:0]        wrValid = '0;
  logic [NUM_Q*BYTE_W-1:0] wrBytes = '0;
  logic [NUM_Q-1:0]        wrEop = '0;
  logic [NUM_Q-1:0]        rdValid = '0;
  logic [NUM_Q-1:0]        rdEop = '0;
  logic [NUM_Q-1:0]        grant;
  logic [NUM_Q-1:0]        oversize;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  txq_release #(.NUM_Q(NUM_Q), .BEAT_BYTES(BEAT), .SIZE_W(SIZE_W)) dut_i (
    .clk(clk), .rstN(rstN), .sfEn(sfEn), .thrCode(thrCode), .sizeCode(sizeCode),
    .wrValid(wrValid), .wrBytes(wrBytes), .wrEop(wrEop),
    .rdValid(rdValid), .rdEop(rdEop), .grant(grant), .oversize(oversize)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeBeat(input int q, input int nb, input logic eop);
    @(negedge clk);
    wrValid[q] = 1'b1;
    wrBytes[q*BYTE_W +: BYTE_W] = BYTE_W'(nb);
    wrEop[q] = eop;
    @(negedge clk);
    wrValid[q] = 1'b0;
    wrEop[q] = 1'b0;
  endtask

  task automatic readBeat(input int q, input logic eop);
    @(negedge clk);
    rdValid[q] = 1'b1;
    rdEop[q] = eop;
    @(negedge clk);
    rdValid[q] = 1'b0;
    rdEop[q] = 1'b0;
  endtask

  task automatic writeFull(input int q, input int n);
    for (int b = 0; b < n; b++) writeBeat(q, BEAT, 1'b0);
  endtask

  task automatic cleanup(input int q);
    if (!grant[q]) begin
      writeBeat(q, 1, 1'b1);
      idle(1);
    end
    readBeat(q, 1'b1);
    idle(1);
  endtask

  initial begin
    idle(3);
    check("R11 reset grant", |grant, 1'b0);
    check("R11 reset oversize", |oversize, 1'b0);
    rstN = 1'b1;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TABLE[i];
      sfEn = '0;
      sfEn[v.q] = v.sf;
      thrCode[v.q*3 +: 3] = v.thr;
      sizeCode[v.q*SIZE_W +: SIZE_W] = v.size;
      idle(1);
      writeFull(v.q, int'(v.nFull));
      writeBeat(v.q, int'(v.last), v.eop);
      idle(1);
      check($sformatf("R1/R2/R3/R4/R6 vector %0d grant", i), grant[v.q], v.expG);
      check($sformatf("R6 vector %0d oversize", i), oversize[v.q], v.expO);
      cleanup(v.q);
    end
    sfEn = '0;
    thrCode = '0;
    sizeCode = '1;
    idle(1);

    // R9: grant rises one edge after the qualifying beat is registered
    writeFull(0, 4);
    writeBeat(0, 1, 1'b0);
    check("R9 grant not yet", grant[0], 1'b0);
    idle(1);
    check("R9 grant one edge later", grant[0], 1'b1);

    // R7: non-final reads keep the grant
    for (int k = 0; k < 3; k++) begin
      readBeat(0, 1'b0);
      check("R7 grant held", grant[0], 1'b1);
    end
    // R8: final read drops it at that edge
    readBeat(0, 1'b1);
    check("R8 grant dropped", grant[0], 1'b0);
    writeBeat(0, 16, 1'b0);
    idle(1);
    check("R8 tally restarted", grant[0], 1'b0);
    writeFull(0, 4);
    idle(1);
    check("R8 next packet grant", grant[0], 1'b1);
    cleanup(0);

    // R10: stray read on an ungranted queue leaves the tally alone
    writeFull(1, 4);
    readBeat(1, 1'b1);
    check("R10 no grant after stray read", grant[1], 1'b0);
    writeBeat(1, 1, 1'b0);
    idle(1);
    check("R10 tally kept (65 bytes)", grant[1], 1'b1);
    cleanup(1);

    // R5: mode bit is per queue
    sfEn = 8'b0000_0100;
    idle(1);
    writeFull(2, 5);
    writeFull(3, 5);
    idle(1);
    check("R5 queue2 whole-packet waits", grant[2], 1'b0);
    check("R5 queue3 cut-through released", grant[3], 1'b1);
    check("R6 no oversize in cut-through", oversize[3], 1'b0);
    cleanup(2);
    cleanup(3);
    sfEn = '0;

    // R11: reset mid-run clears a live grant
    writeFull(5, 5);
    idle(1);
    check("R11 grant before reset", grant[5], 1'b1);
    rstN = 1'b0;
    idle(2);
    check("R11 grant cleared by reset", grant[5], 1'b0);
    rstN = 1'b1;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule